// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block produces the byte a NOR-style flash part presents on its data pins during a read. While the part is idle it passes array data straight through. Once a program or erase command has been fully entered, it switches to a status byte. In that byte, bit 6 inverts on every new read access. Bit 3 shows whether an erase is still waiting for its start timeout. Bit 5 reports a failed operation and keeps reporting it until a reset command arrives.

The block is one clock domain, and every input is sampled on the rising edge of `clk`. A read access begins when the combined strobe (chip enable low and output enable low) becomes active. The command decoder pulses `prog_start` after the fourth write of a program sequence, or `erase_start` after the sixth write of an erase sequence. With either pulse it gives `prot_hit` to say whether the target is protected. The internal controller reports the end of an operation with `op_done` and `op_fail`.

The states are named as follows.
- ST_READ (idle) has these transitions:
  - to ST_EWAIT on an unprotected erase;
  - to ST_PWIN on a fully protected erase;
  - to ST_BUSY on an unprotected program.
- ST_EWAIT goes to ST_BUSY when the erase-start timer expires.
- ST_BUSY has two exits:
  - to ST_READ on `op_done` without `op_fail`;
  - to ST_FAIL on `op_done` with `op_fail`.
- ST_PWIN goes to ST_READ when the protected window timer expires.
- ST_FAIL goes to ST_READ on `reset_cmd`.

Top module: `fpe_status_gen`

## Requirements
- R1: After reset the block is idle and `dout` equals `arr_data`.
- R2: While idle, `dout` follows `arr_data` in the same cycle for any value.
- R3: In any non-idle state `dout` is the status byte {0, tog, err, 0, tmr, 0, 0, 0}. Its fields are as follows:
  - tog is bit 6;
  - err is bit 5, and reads 1 only in ST_FAIL;
  - tmr is bit 3, and reads 0 only in ST_EWAIT;
  - all other bits read 0.
- R4: The toggle bit has the following behaviour:
  - it clears to 0 when an operation is accepted;
  - it inverts once at the start of each read access, that is, in the cycle after the combined strobe goes from inactive to active;
  - an access started by pulsing either chip enable or output enable counts;
  - a held access does not invert it again;
  - no access, no change.
- R5: An unprotected erase holds bit 3 at 0 for exactly ERASE_TMO cycles after the start pulse and then moves to ST_BUSY with bit 3 at 1.
- R6: An erase whose targets are all protected shows the toggling status with bit 3 at 1 for exactly PROT_WIN cycles, then returns to idle with no error.
- R7: A program start with `prot_hit` set is ignored: `dout` keeps passing array data.
- R8: `op_done` without `op_fail` in ST_BUSY returns the block to idle on the next cycle.
- R9: `op_done` with `op_fail` in ST_BUSY sets bit 5. The block stays in ST_FAIL, still toggling, through further `op_done`, start pulses and accesses, until `reset_cmd` returns it to idle.
- R10: `reset_cmd` has no effect outside ST_FAIL.
- R11: When `prog_start` and `erase_start` arrive together, the erase is taken. Start pulses outside ST_READ are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| arr_data | input | 8 | Array read data |
| prog_start | input | 1 | Program command fully entered (pulse) |
| erase_start | input | 1 | Erase command fully entered (pulse) |
| prot_hit | input | 1 | Target of the starting command is protected |
| op_done | input | 1 | Internal controller finished the operation |
| op_fail | input | 1 | Operation failed, valid with op_done |
| reset_cmd | input | 1 | Reset command received (pulse) |
| dout | output | 8 | Read data or status byte |

## Verification
The hardest condition to reach from the ports is a failed operation that must stay latched while everything else keeps moving. Reaching it takes an erase that passes its whole start timeout, enters ST_BUSY and is then ended with a failure. After that, further reads must keep the toggle running while completion and start pulses are offered and must be refused. The bench builds this path in sequence. It counts the timeout cycles exactly and interleaves read accesses, so that bit 5, bit 6 and the final release by the reset command are each seen at a known cycle. Read accesses of both strobe kinds, as well as held accesses, are walked from a vector table during a program.

// File: rtl/fpe_stat_pkg.sv
package fpe_stat_pkg;
    typedef enum logic [2:0] {
        ST_READ  = 3'd0,
        ST_EWAIT = 3'd1,
        ST_BUSY  = 3'd2,
        ST_PWIN  = 3'd3,
        ST_FAIL  = 3'd4
    } fpe_state_e;

    localparam int TOG_POS = 6;
    localparam int ERR_POS = 5;
    localparam int TMR_POS = 3;
    localparam int DATA_W  = 8;
endpackage

// File: rtl/fpe_rd_edge.sv
module fpe_rd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic acc_start
);
    logic rd_now;
    logic rd_q;

    assign rd_now = ~ce_n & ~oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_now;
    end

    assign acc_start = rd_now & ~rd_q;

    // R4
    acc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_start |=> !acc_start);
endmodule

// File: rtl/fpe_toggle.sv
module fpe_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic tog
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tog <= 1'b0;
        else if (clr)  tog <= 1'b0;
        else if (step) tog <= ~tog;
    end

    // R4
    tog_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> tog != $past(tog));
    // R4
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(tog));
endmodule

// File: rtl/fpe_win_timer.sv
module fpe_win_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] init,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= init;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R5
    tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/fpe_status_gen.sv
module fpe_status_gen #(
    parameter int ERASE_TMO = 100,
    parameter int PROT_WIN  = 120
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic [7:0] arr_data,
    input  logic       prog_start,
    input  logic       erase_start,
    input  logic       prot_hit,
    input  logic       op_done,
    input  logic       op_fail,
    input  logic       reset_cmd,
    output logic [7:0] dout
);
    import fpe_stat_pkg::*;

    localparam int MAX_WIN = (ERASE_TMO > PROT_WIN) ? ERASE_TMO : PROT_WIN;
    localparam int CNT_W   = $clog2(MAX_WIN + 1);

    fpe_state_e state_q, state_d;
    logic acc_start, tog, tmr_zero;
    logic take_erase, take_prog, accepted;
    logic [CNT_W-1:0] tmr_init;

    assign take_erase = (state_q == ST_READ) && erase_start;
    assign take_prog  = (state_q == ST_READ) && prog_start && !erase_start && !prot_hit;
    assign accepted   = take_erase | take_prog;
    assign tmr_init   = prot_hit ? CNT_W'(PROT_WIN - 1) : CNT_W'(ERASE_TMO - 1);

    fpe_rd_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .acc_start(acc_start)
    );

    fpe_toggle u_tog (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accepted),
        .step (acc_start && (state_q != ST_READ)),
        .tog  (tog)
    );

    fpe_win_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (take_erase),
        .init (tmr_init),
        .zero (tmr_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ: begin
                if (erase_start)
                    state_d = prot_hit ? ST_PWIN : ST_EWAIT;
                else if (prog_start && !prot_hit)
                    state_d = ST_BUSY;
            end
            ST_EWAIT: if (tmr_zero) state_d = ST_BUSY;
            ST_BUSY:  if (op_done)  state_d = op_fail ? ST_FAIL : ST_READ;
            ST_PWIN:  if (tmr_zero) state_d = ST_READ;
            ST_FAIL:  if (reset_cmd) state_d = ST_READ;
            default:  state_d = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READ;
        else        state_q <= state_d;
    end

    always_comb begin
        dout = '0;
        unique case (state_q)
            ST_READ: dout = arr_data;
            ST_EWAIT: begin
                dout[TOG_POS] = tog;
            end
            ST_BUSY, ST_PWIN: begin
                dout[TOG_POS] = tog;
                dout[TMR_POS] = 1'b1;
            end
            ST_FAIL: begin
                dout[TOG_POS] = tog;
                dout[ERR_POS] = 1'b1;
                dout[TMR_POS] = 1'b1;
            end
            default: dout = arr_data;
        endcase
    end

    // R9
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIL && !reset_cmd) |=> state_q == ST_FAIL);
    // R7
    prot_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && prog_start && prot_hit && !erase_start) |=> state_q == ST_READ);
    // R5
    ewait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EWAIT && !tmr_zero) |=> state_q == ST_EWAIT);
    // R8
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && op_done && !op_fail) |=> state_q == ST_READ);
    // R10
    rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && reset_cmd && !op_done) |=> state_q == ST_BUSY);
endmodule

// File: tb/fpe_status_gen_test.sv
module fpe_status_gen_test;
    localparam int CLK_PER = 10;
    localparam int ETMO    = 5;
    localparam int PWIN    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1;
    logic [7:0] arr_data = 8'h5A;
    logic prog_start = 1'b0, erase_start = 1'b0, prot_hit = 1'b0;
    logic op_done = 1'b0, op_fail = 1'b0, reset_cmd = 1'b0;
    logic [7:0] dout;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    fpe_status_gen #(.ERASE_TMO(ETMO), .PROT_WIN(PWIN)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .arr_data(arr_data), .prog_start(prog_start), .erase_start(erase_start),
        .prot_hit(prot_hit), .op_done(op_done), .op_fail(op_fail),
        .reset_cmd(reset_cmd), .dout(dout)
    );

    // kind: 0 = output-enable pulse, 1 = chip-enable pulse, 2 = no access, 3 = held access
    localparam logic [9:0] VEC [8] = '{
        {2'd0, 8'h48}, {2'd0, 8'h08}, {2'd2, 8'h08}, {2'd1, 8'h48},
        {2'd3, 8'h08}, {2'd1, 8'h48}, {2'd2, 8'h48}, {2'd0, 8'h08}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic [1:0] kind);
        case (kind)
            2'd0: begin ce_n = 1'b0; oe_n = 1'b0; tick(); end
            2'd1: begin oe_n = 1'b0; ce_n = 1'b0; tick(); end
            2'd3: begin ce_n = 1'b0; oe_n = 1'b0; tick(); tick(); tick(); end
            default: tick();
        endcase
        ce_n = 1'b1; oe_n = 1'b1;
        tick();
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1; tick(); sig = 1'b0;
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        chk("R1", dout, 8'h5A);
        arr_data = 8'hC3; #1;
        chk("R2", dout, 8'hC3);

        // R7: protected program ignored
        prot_hit = 1'b1; pulse(prog_start); prot_hit = 1'b0;
        access(2'd0);
        chk("R7", dout, 8'hC3);

        // R3 / R4: program busy, vector walk
        pulse(prog_start);
        chk("R3", dout, 8'h08);
        for (int i = 0; i < 8; i++) begin
            access(VEC[i][9:8]);
            chk("R4", dout, VEC[i][7:0]);
        end
        pulse(reset_cmd);
        chk("R10", dout, 8'h08);
        pulse(erase_start);
        chk("R11", dout, 8'h08);
        pulse(op_done);
        chk("R8", dout, 8'hC3);

        // R5: unprotected erase, start timer window
        pulse(erase_start);
        chk("R5", dout, 8'h00);
        repeat (ETMO - 1) tick();
        chk("R5", dout, 8'h00);
        tick();
        chk("R5", dout, 8'h08);
        access(2'd0);
        chk("R4", dout, 8'h48);

        // R9: failure latched
        op_fail = 1'b1; pulse(op_done); op_fail = 1'b0;
        chk("R9", dout, 8'h68);
        access(2'd1);
        chk("R9", dout, 8'h28);
        pulse(op_done);
        pulse(prog_start);
        pulse(erase_start);
        chk("R9", dout, 8'h28);
        pulse(reset_cmd);
        chk("R9", dout, 8'hC3);

        // R6: fully protected erase
        prot_hit = 1'b1; pulse(erase_start); prot_hit = 1'b0;
        chk("R6", dout, 8'h08);
        access(2'd0);
        chk("R6", dout, 8'h48);
        repeat (PWIN - 3) tick();
        chk("R6", dout, 8'h48);
        tick();
        chk("R6", dout, 8'hC3);

        // R11: simultaneous starts, erase wins
        prog_start = 1'b1; erase_start = 1'b1; tick();
        prog_start = 1'b0; erase_start = 1'b0;
        chk("R11", dout, 8'h00);
        repeat (ETMO) tick();
        pulse(op_done);
        chk("R8", dout, 8'hC3);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule